// File: doc/BRIEF.md
# Unsigned Integer and Single-Precision Float Converter Pair

This block holds two independent converters between IEEE-754 single-precision values and 32-bit unsigned integers. The float-to-unsigned path sorts its operand into zero, denormal, infinity, NaN or normal. It saturates anything outside the unsigned range and drops any fraction, so it always truncates toward zero. It reports an invalid flag for results it cannot represent and an unimplemented flag for denormal operands. A flush control turns denormal operands into signed zeros instead.

The unsigned-to-float path shifts the integer left until its top bit is set. It keeps a 24-bit significand and rounds off the bits shifted out, under one of four rounding modes. It then encodes the result with a biased exponent. It also reports whether the result is zero, and a sign flag that is always clear.

Both paths compute in one combinational stage. Their results are captured together in one output register, so each result appears one clock after its operands are applied.

Top module: `fu_convert_pair`

## Requirements
- R1: Float-to-unsigned returns 0 with neither flag set for +0.0 and -0.0.
- R2: Float-to-unsigned returns 0xFFFFFFFF for +infinity and 0x00000000 for -infinity, and raises invalid in both cases.
- R3: For a NaN operand (exponent field all ones, mantissa nonzero), float-to-unsigned raises invalid. It returns 0 when bit 31 is set and 0xFFFFFFFF when bit 31 is clear.
- R4: A denormal operand (exponent field 0, mantissa nonzero) with flush low raises unimplemented and returns 0. With flush high it is handled as a signed zero: the result is 0 with no flag. Invalid and unimplemented are never set together.
- R5: Any other negative finite operand returns 0 with no flag, whatever its magnitude.
- R6: A positive normal operand whose unbiased exponent (field minus 127) is 32 or more raises invalid and returns 0xFFFFFFFF.
- R7: A positive normal operand in range returns its value truncated toward zero. An unbiased exponent below 0 gives 0.
- R8: Unsigned-to-float with input 0 returns 0x00000000 and sets the zero flag.
- R9: A nonzero input with at most 24 significant bits is converted exactly. The exponent field is 127 plus the index of the highest set bit, and the mantissa field holds the bits below the leading one.
- R10: Rounding mode codes are 0 nearest, 1 toward zero, 2 toward plus infinity and 3 toward minus infinity. Of the 8 bits dropped after normalization, mode 0 adds one when the top dropped bit is set, mode 2 adds one when any dropped bit is set, and modes 1 and 3 never add.
- R11: If rounding carries the significand out of 24 bits, the significand is shifted right by one and the exponent rises by one (for example, 0xFFFFFFFF in mode 0 gives 0x4F800000).
- R12: The unsigned-to-float result always has bit 31 clear, and the sign flag is always 0.
- R13: Reset clears every output. Each result appears one clock after its operands are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| f_in | input | 32 | Single-precision operand for float-to-unsigned |
| flush_den | input | 1 | Treat denormal operands as signed zeros |
| u_in | input | 32 | Unsigned operand for unsigned-to-float |
| rnd_mode | input | 2 | Rounding mode for unsigned-to-float |
| u_out | output | 32 | Float-to-unsigned result |
| f2u_invalid | output | 1 | Float-to-unsigned invalid operation |
| f2u_unimpl | output | 1 | Float-to-unsigned denormal operand not converted |
| f_out | output | 32 | Unsigned-to-float result |
| u2f_zero | output | 1 | Unsigned-to-float result is zero |
| u2f_sign | output | 1 | Unsigned-to-float sign flag, always 0 |

## Verification
The bench builds the block with its default parameters: 8-bit exponent, 23-bit mantissa and 32-bit integer. Because the exponent field is only 8 bits wide, every exponent value can be swept with both signs, both flush settings and a set of corner mantissas. That reaches every classification, the saturation threshold at unbiased exponent 32 and each truncation shift. On the integer side, every leading-one position is swept with minimal, full and random low bits under all four rounding modes, together with random integers. This reaches the exact range, each rounding rule and the carry-out renormalization.

// File: rtl/fu_pkg.sv
package fu_pkg;

    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_POS  = 2'd2,
        RND_NEG  = 2'd3
    } rnd_e;

    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_DENORM = 3'd1,
        CLS_INF    = 3'd2,
        CLS_NAN    = 3'd3,
        CLS_NORMAL = 3'd4
    } fcls_e;

endpackage

// File: rtl/fu_classify.sv
module fu_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W-1:0] exp_f,
    input  logic [MAN_W-1:0] man_f,
    input  logic             flush,
    output fu_pkg::fcls_e    cls
);
    import fu_pkg::*;

    logic exp_zero;
    logic exp_ones;
    logic man_zero;

    always_comb begin
        exp_zero = (exp_f == '0);
        exp_ones = (exp_f == '1);
        man_zero = (man_f == '0);
        if (exp_zero) begin
            // a flushed denormal behaves as a signed zero
            cls = (man_zero || flush) ? CLS_ZERO : CLS_DENORM;
        end else if (exp_ones) begin
            cls = man_zero ? CLS_INF : CLS_NAN;
        end else begin
            cls = CLS_NORMAL;
        end
    end

endmodule

// File: rtl/fu_lzc.sv
module fu_lzc #(
    parameter int W  = 32,
    parameter int LW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [LW-1:0] lz
);
    always_comb begin
        lz = '0;
        // the highest set bit is visited last and wins
        for (int i = 0; i < W; i++) begin
            if (vec[i]) lz = LW'(W - 1 - i);
        end
    end

endmodule

// File: rtl/f2u_core.sv
module f2u_core #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32
) (
    input  logic [EXP_W+MAN_W:0] f_val,
    input  logic                 flush,
    output logic [INT_W-1:0]     u_val,
    output logic                 invalid,
    output logic                 unimpl
);
    import fu_pkg::*;

    localparam int FW   = EXP_W + MAN_W + 1;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int UEW  = EXP_W + 2;
    localparam int SW   = INT_W + MAN_W + 1;
    localparam int SHW  = $clog2(INT_W);

    logic             sgn;
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    fcls_e            cls;
    logic [UEW-1:0]   ue;
    logic [SW-1:0]    sig_ext;
    logic [SW-1:0]    shifted;

    assign sgn   = f_val[FW-1];
    assign exp_f = f_val[FW-2 -: EXP_W];
    assign man_f = f_val[MAN_W-1:0];

    fu_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
        .exp_f (exp_f),
        .man_f (man_f),
        .flush (flush),
        .cls   (cls)
    );

    always_comb begin
        ue      = UEW'(exp_f) - UEW'(BIAS);
        sig_ext = SW'({1'b1, man_f});
        shifted = sig_ext << ue[SHW-1:0];
        u_val   = '0;
        invalid = 1'b0;
        unimpl  = 1'b0;
        unique case (cls)
            CLS_ZERO: begin
                u_val = '0;
            end
            CLS_DENORM: begin
                unimpl = 1'b1;
            end
            CLS_INF, CLS_NAN: begin
                invalid = 1'b1;
                u_val   = sgn ? '0 : '1;
            end
            default: begin
                if (sgn || ue[UEW-1]) begin
                    u_val = '0;
                end else if (ue >= UEW'(INT_W)) begin
                    invalid = 1'b1;
                    u_val   = '1;
                end else begin
                    // the fraction falls off the bottom: truncation
                    u_val = shifted[MAN_W +: INT_W];
                end
            end
        endcase
    end

endmodule

// File: rtl/u2f_core.sv
module u2f_core #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32
) (
    input  logic [INT_W-1:0]     u_val,
    input  logic [1:0]           rnd,
    output logic [EXP_W+MAN_W:0] f_val,
    output logic                 zero
);
    import fu_pkg::*;

    localparam int KEEP = MAN_W + 1;
    localparam int FRAC = INT_W - KEEP;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int LW   = $clog2(INT_W);

    logic [LW-1:0]    lz;
    logic [INT_W-1:0] norm;
    logic [KEEP-1:0]  keep;
    logic [FRAC-1:0]  frac;
    logic             inc;
    logic [KEEP:0]    sum;
    logic [MAN_W-1:0] man_r;
    logic [EXP_W-1:0] exp_r;

    fu_lzc #(.W(INT_W), .LW(LW)) u_lzc (
        .vec (u_val),
        .lz  (lz)
    );

    always_comb begin
        norm = u_val << lz;
        keep = norm[INT_W-1 -: KEEP];
        frac = norm[FRAC-1:0];
        unique case (rnd_e'(rnd))
            RND_NEAR: inc = frac[FRAC-1];
            RND_POS:  inc = (frac != '0);
            default:  inc = 1'b0;
        endcase
        sum = {1'b0, keep} + (KEEP+1)'(inc);
        if (sum[KEEP]) begin
            man_r = sum[MAN_W:1];
        end else begin
            man_r = sum[MAN_W-1:0];
        end
        exp_r = EXP_W'(INT_W - 1 + BIAS) - EXP_W'(lz) + EXP_W'(sum[KEEP]);
        zero  = (u_val == '0);
        f_val = zero ? '0 : {1'b0, exp_r, man_r};
    end

endmodule

// File: rtl/fu_convert_pair.sv
module fu_convert_pair #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [EXP_W+MAN_W:0]   f_in,
    input  logic                   flush_den,
    input  logic [INT_W-1:0]       u_in,
    input  logic [1:0]             rnd_mode,
    output logic [INT_W-1:0]       u_out,
    output logic                   f2u_invalid,
    output logic                   f2u_unimpl,
    output logic [EXP_W+MAN_W:0]   f_out,
    output logic                   u2f_zero,
    output logic                   u2f_sign
);
    localparam int FW = EXP_W + MAN_W + 1;

    typedef struct packed {
        logic [INT_W-1:0] u_val;
        logic             inv;
        logic             uni;
        logic [FW-1:0]    f_val;
        logic             zero;
        logic             sign;
    } res_t;

    res_t             res_d;
    res_t             res_q;
    logic [INT_W-1:0] cu_val;
    logic             cu_inv;
    logic             cu_uni;
    logic [FW-1:0]    cf_val;
    logic             cf_zero;

    f2u_core #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_f2u (
        .f_val   (f_in),
        .flush   (flush_den),
        .u_val   (cu_val),
        .invalid (cu_inv),
        .unimpl  (cu_uni)
    );

    u2f_core #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_u2f (
        .u_val (u_in),
        .rnd   (rnd_mode),
        .f_val (cf_val),
        .zero  (cf_zero)
    );

    always_comb begin
        res_d       = res_q;
        res_d.u_val = cu_val;
        res_d.inv   = cu_inv;
        res_d.uni   = cu_uni;
        res_d.f_val = cf_val;
        res_d.zero  = cf_zero;
        res_d.sign  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign u_out       = res_q.u_val;
    assign f2u_invalid = res_q.inv;
    assign f2u_unimpl  = res_q.uni;
    assign f_out       = res_q.f_val;
    assign u2f_zero    = res_q.zero;
    assign u2f_sign    = res_q.sign;

endmodule

// File: rtl/fu_convert_chk.sv
module fu_convert_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [EXP_W+MAN_W:0] f_in,
    input logic                 flush_den,
    input logic [INT_W-1:0]     u_in,
    input logic [INT_W-1:0]     u_out,
    input logic                 f2u_invalid,
    input logic                 f2u_unimpl,
    input logic [EXP_W+MAN_W:0] f_out,
    input logic                 u2f_zero,
    input logic                 u2f_sign
);
    localparam int FW = EXP_W + MAN_W + 1;

    logic             in_sgn;
    logic [EXP_W-1:0] in_exp;
    logic [MAN_W-1:0] in_man;

    assign in_sgn = f_in[FW-1];
    assign in_exp = f_in[FW-2 -: EXP_W];
    assign in_man = f_in[MAN_W-1:0];

    AST_NAN_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exp == '1 && in_man != '0 && in_sgn) |=> (f2u_invalid && u_out == '0)); // R3

    AST_NEG_FINITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sgn && in_exp != '1 && in_exp != '0) |=> (u_out == '0 && !f2u_invalid && !f2u_unimpl)); // R5

    AST_FLUSH_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exp == '0 && flush_den) |=> (u_out == '0 && !f2u_unimpl && !f2u_invalid)); // R4

    AST_UNIMPL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        f2u_unimpl |-> (u_out == '0 && !f2u_invalid)); // R4

    AST_INVALID_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        f2u_invalid |-> (u_out == '0 || u_out == '1)); // R6

    AST_U2F_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (u_in == '0) |=> (f_out == '0 && u2f_zero)); // R8

    AST_U2F_NONZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (u_in != '0) |=> (!u2f_zero && f_out[FW-2 -: EXP_W] != '0)); // R9

    AST_U2F_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!u2f_sign && !f_out[FW-1])); // R12

endmodule

bind fu_convert_pair fu_convert_chk #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .f_in        (f_in),
    .flush_den   (flush_den),
    .u_in        (u_in),
    .u_out       (u_out),
    .f2u_invalid (f2u_invalid),
    .f2u_unimpl  (f2u_unimpl),
    .f_out       (f_out),
    .u2f_zero    (u2f_zero),
    .u2f_sign    (u2f_sign)
);

// File: tb/sim_fu_convert_pair.sv
module sim_fu_convert_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] f_in = '0;
    logic        flush_den = 1'b0;
    logic [31:0] u_in = '0;
    logic [1:0]  rnd_mode = '0;
    logic [31:0] u_out;
    logic        f2u_invalid;
    logic        f2u_unimpl;
    logic [31:0] f_out;
    logic        u2f_zero;
    logic        u2f_sign;

    int checks = 0;
    int fails = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    fu_convert_pair u0 (
        .clk(clk), .rst_n(rst_n), .f_in(f_in), .flush_den(flush_den),
        .u_in(u_in), .rnd_mode(rnd_mode), .u_out(u_out),
        .f2u_invalid(f2u_invalid), .f2u_unimpl(f2u_unimpl),
        .f_out(f_out), .u2f_zero(u2f_zero), .u2f_sign(u2f_sign)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    task automatic f2u_ref(input logic [31:0] f, input logic fl, output logic [31:0] v,
                           output logic inv, output logic uni, output string tag);
        int e;
        int ue;
        longint sig;
        e = int'(f[30:23]);
        v = '0; inv = 1'b0; uni = 1'b0;
        if (e == 0) begin
            if (f[22:0] == 0) tag = "R1";
            else if (fl) tag = "R4";
            else begin tag = "R4"; uni = 1'b1; end
        end else if (e == 255) begin
            inv = 1'b1;
            v = f[31] ? 32'h0 : 32'hFFFF_FFFF;
            tag = (f[22:0] == 0) ? "R2" : "R3";
        end else if (f[31]) begin
            tag = "R5";
        end else begin
            ue = e - 127;
            if (ue >= 32) begin
                inv = 1'b1; v = 32'hFFFF_FFFF; tag = "R6";
            end else begin
                tag = "R7";
                sig = longint'(f[22:0]) + (longint'(1) << 23);
                if (ue < 0) v = 32'h0;
                else if (ue >= 23) v = 32'(sig << (ue - 23));
                else v = 32'(sig >> (23 - ue));
            end
        end
    endtask

    task automatic u2f_ref(input logic [31:0] u, input logic [1:0] md,
                           output logic [31:0] f, output string tag);
        int msb;
        int sh;
        longint q;
        longint rem;
        logic inc;
        msb = 0;
        if (u == 0) begin
            f = 32'h0; tag = "R8";
        end else begin
            for (int i = 0; i < 32; i++) if (u[i]) msb = i;
            sh = msb - 23;
            inc = 1'b0;
            if (sh <= 0) begin
                q = longint'(u) << (-sh); rem = 0; tag = "R9";
            end else begin
                q = longint'(u) >> sh;
                rem = longint'(u) - (q << sh);
                tag = "R10";
                if (md == 2'd0) inc = (rem >= (longint'(1) << (sh - 1)));
                if (md == 2'd2) inc = (rem != 0);
            end
            q = q + longint'(inc);
            if (q == (longint'(1) << 24)) begin
                q = q >> 1; msb = msb + 1; tag = "R11";
            end
            f = {1'b0, 8'(msb + 127), q[22:0]};
        end
    endtask

    task automatic step(input logic [31:0] f, input logic fl, input logic [31:0] u, input logic [1:0] md);
        logic [31:0] ev;
        logic [31:0] ef;
        logic einv;
        logic euni;
        string t1;
        string t2;
        @(negedge clk);
        f_in = f; flush_den = fl; u_in = u; rnd_mode = md;
        @(negedge clk);
        f2u_ref(f, fl, ev, einv, euni, t1);
        u2f_ref(u, md, ef, t2);
        chk(t1, u_out, ev);
        chk(t1, 32'(f2u_invalid), 32'(einv));
        chk(t1, 32'(f2u_unimpl), 32'(euni));
        chk(t2, f_out, ef);
        chk("R8", 32'(u2f_zero), 32'(u == 0));
        chk("R12", 32'(u2f_sign), 32'h0);
    endtask

    initial begin
        logic [22:0] mans [5];
        #1;
        // R13: outputs cleared while reset is held
        f_in = 32'h7F80_0000; u_in = 32'h1234_5678;
        repeat (2) @(negedge clk);
        chk("R13", u_out, 32'h0);
        chk("R13", f_out, 32'h0);
        chk("R13", {29'h0, f2u_invalid, f2u_unimpl, u2f_zero}, 32'h0);
        rst_n = 1'b1;
        // R13: result one clock after the operands
        @(negedge clk);
        f_in = 32'h4120_0000; u_in = 32'd5; rnd_mode = 2'd0;
        @(negedge clk);
        chk("R13", u_out, 32'd10);
        chk("R13", f_out, 32'h40A0_0000);

        // float-to-unsigned sweep over every exponent field value
        for (int s = 0; s < 2; s++) begin
            for (int e = 0; e < 256; e++) begin
                next_rand();
                mans[0] = 23'h0; mans[1] = 23'h1; mans[2] = 23'h40_0000;
                mans[3] = 23'h7F_FFFF; mans[4] = lfsr[22:0];
                for (int m = 0; m < 5; m++) begin
                    for (int fl = 0; fl < 2; fl++) begin
                        next_rand();
                        step({1'(s), 8'(e), mans[m]}, 1'(fl), lfsr, lfsr[1:0]);
                    end
                end
            end
        end

        // unsigned-to-float sweep over every leading-one position
        for (int sh = 0; sh < 32; sh++) begin
            for (int md = 0; md < 4; md++) begin
                next_rand();
                step(32'h0, 1'b0, 32'h1 << sh, 2'(md));
                step(32'h0, 1'b0, (32'h1 << sh) | ((32'h1 << sh) - 1), 2'(md));
                step(32'h0, 1'b0, (32'h1 << sh) | (lfsr & ((32'h1 << sh) - 1)), 2'(md));
                step(32'h0, 1'b0, (32'h1 << sh) | (32'h80 << (sh > 8 ? sh - 8 : 0)) & ((32'h1 << sh) - 1), 2'(md));
            end
        end

        // named corners
        step(32'h8000_0000, 1'b0, 32'h0, 2'd0);          // R1 -0.0, R8 zero in
        step(32'h7F80_0000, 1'b0, 32'hFFFF_FFFF, 2'd0);  // R2, R11 carry
        chk("R11", f_out, 32'h4F80_0000);
        step(32'hFF80_0000, 1'b0, 32'h0100_0001, 2'd2);  // R2, R10 plus inf
        chk("R10", f_out, 32'h4B80_0001);
        step(32'h7FC0_0000, 1'b0, 32'h0100_0001, 2'd3);  // R3, R10 minus inf
        chk("R10", f_out, 32'h4B80_0000);
        step(32'h0000_0001, 1'b1, 32'h00FF_FFFF, 2'd1);  // R4 flush, R9 exact
        chk("R9", f_out, 32'h4B7F_FFFF);
        step(32'h4F80_0000, 1'b0, 32'd1, 2'd0);          // R6 2^32, R9
        chk("R6", u_out, 32'hFFFF_FFFF);
        step(32'h4F7F_FFFF, 1'b0, 32'd1, 2'd0);          // R7 largest in range
        chk("R7", u_out, 32'hFFFF_FF00);
        step(32'h3FFF_FFFF, 1'b0, 32'd1, 2'd0);          // R7 1.99 truncates
        chk("R7", u_out, 32'd1);
        step(32'hCF80_0000, 1'b0, 32'd1, 2'd0);          // R5 huge negative
        chk("R5", u_out, 32'h0);

        for (int k = 0; k < 3000; k++) begin
            next_rand();
            step(lfsr, lfsr[7], lfsr ^ 32'h5A5A_3C3C, lfsr[5:4]);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 190000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule